// File: doc/BRIEF.md
# Dual Auto-Reload Timer/Counter

This block holds two independent timer/counters. Each one is built from a low count byte and a high count byte, and each has a pair of 8-bit reload registers. A mode field selects one of four ways to combine the two bytes. Each unit counts one of two event sources:

- ticks of a shared timer clock, taken from the oscillator (the block clock) divided by 4, 16 or 64;
- falling edges on its own external count pin, after the pin has been resynchronised.

A unit can also be gated by an external gate pin. When a unit overflows it either raises its interrupt flag or, if its toggle output is enabled, inverts its toggle pin.

Software reaches the block through a flat byte-wide register port. Writes are synchronous. Reads are combinational from the read address. An interrupt controller returns a one-cycle acknowledge pulse per channel, and that pulse clears the matching flag. Mode 3 splits unit 0 into two 8-bit counters. The upper half then borrows the run bit and the flag/toggle channel of unit 1, and unit 1 freezes.

Top module: `twin_reload_timer`

## Requirements
- R1: Register map, all reset to 0:
  - 0 is the control byte. Bits [1:0] are mode of unit 0, bit [2] selects counter mode for unit 0, bit [3] is the gate enable for unit 0. Bits [7:4] hold the same fields for unit 1.
  - 1 is the run/status byte. Bits [1:0] are run, [3:2] are the flags (also `irq`), [5:4] are the toggle-output enables, [7:6] are the clock select.
  - For unit n, address 2+4n is the low count, 3+4n the high count, 4+4n the low reload and 5+4n the high reload.
  - Addresses 10 to 15 read 0.
  - Every mapped register reads back what was last written.
- R2: The clock select values 0, 1 and 2 produce one timer tick every 4, 16 or 64 cycles. All three are derived from one free-running divider that starts at reset, so a tick falls on every cycle whose count since reset, modulo the divisor, equals the divisor minus 1. Select value 3 produces no ticks.
- R3: Mode 0 counts 16 bits. An event at 0xFFFF loads both count bytes from the reload pair and raises the channel overflow.
- R4: Mode 1 counts 16 bits. An event at 0xFFFF wraps the count to 0x0000 and raises the channel overflow.
- R5: Mode 2 counts the low byte only. An event at 0xFF loads the low byte from the low reload and raises the overflow. The high byte never changes.
- R6: Mode 3 has different effects on the two units:
  - Unit 1 in mode 3 holds its count.
  - Unit 0 in mode 3 runs its low byte as an 8-bit wrapping counter under its own controls and channel 0.
  - Unit 0's high byte then counts timer ticks while run bit 1 is set, ignoring gate and count-source bits. Its wrap from 0xFF drives channel 1, and unit 1's own overflows no longer reach channel 1.
- R7: With the gate enable set, a unit counts only while its run bit is 1 and its gate pin is high. With the gate enable clear, the run bit alone enables counting.
- R8: In counter mode, each count pin passes through two synchroniser flops and is then sampled every second cycle. A high sample followed by a low sample is one count event. A level held at least 4 cycles is therefore never missed.
- R9: Toggle outputs reset to 0. With a channel's toggle enable set, each overflow on that channel inverts its toggle output and does not set its flag. With the enable clear, the output does not change.
- R10: A channel overflow sets its flag, and `irq` shows the flags. The flag has these set and clear rules:
  - A one-cycle acknowledge pulse clears it.
  - A write of the run/status byte loads it from the written data.
  - A same-cycle write beats a hardware set.
  - A hardware set beats an acknowledge.
- R11: A write to either count byte of a unit cancels that unit's count step and overflow in the same cycle. The written value is what the register holds afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| count_pin | input | 2 | External count inputs, one per unit |
| gate_pin | input | 2 | External gate inputs, one per unit |
| irq_ack | input | 2 | Interrupt acknowledge pulses, one per channel |
| irq | output | 2 | Overflow flags, one per channel |
| tog_out | output | 2 | Overflow toggle outputs, one per channel |

## Verification
Count state is visible in the cycle after it changes, because reads are combinational. A wrong increment, reload or write priority therefore shows on `rd_data` the first time the bench reads that byte. The bench reads a random address every cycle, so such an error surfaces within a few cycles. A divider phase error or a missed edge moves a count by one step within one tick period. Flag and toggle errors appear on `irq` and `tog_out` one cycle after the overflow that caused them, and the bench compares those pins against its own model on every cycle.

// File: rtl/tt_pkg.sv
// Shared constants and types for the dual auto-reload timer.
// Assumes a byte-wide register port with a 4-bit address.
package tt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int N_UNIT = 2;

    typedef enum logic [1:0] {
        MODE_RELOAD16 = 2'd0,
        MODE_FREE16   = 2'd1,
        MODE_RELOAD8  = 2'd2,
        MODE_SPLIT    = 2'd3
    } tmode_e;

    localparam logic [ADDR_W-1:0] A_CTL    = 4'd0;
    localparam logic [ADDR_W-1:0] A_RUN    = 4'd1;
    localparam int                A_BASE   = 2;
    localparam int                A_STRIDE = 4;

    // Address of register 'slot' (0 lo, 1 hi, 2 reload lo, 3 reload hi) of unit n
    function automatic logic [ADDR_W-1:0] unit_addr(input int n, input int slot);
        return ADDR_W'(A_BASE + A_STRIDE * n + slot);
    endfunction
endpackage

// File: rtl/tt_prescale.sv
// Free-running divider producing the shared timer tick.
// Divisors are powers of two taken from one counter, so all selections
// share one phase referenced to reset. Select value 3 gives no tick.
module tt_prescale #(
    parameter int SH_A = 2,
    parameter int SH_B = 4,
    parameter int SH_C = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int PW = SH_C;

    logic [PW-1:0] pcnt_q;

    // Advance the divider every cycle out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_q + PW'(1);
    end

    // Pick the tap that matches the selected divisor
    always_comb begin
        case (sel)
            2'd0:    tick = &pcnt_q[SH_A-1:0];
            2'd1:    tick = &pcnt_q[SH_B-1:0];
            2'd2:    tick = &pcnt_q[SH_C-1:0];
            default: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tt_fall_detect.sv
// Resynchronises N external pins and reports a one-cycle pulse when a
// high sample is followed by a low sample. Samples are taken every
// second cycle, so a level must last 4 cycles to be sure of being seen.
module tt_fall_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] fall
);
    logic phase_q;

    // Sample phase alternates every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic s1_q, s2_q, smp_q, fall_q;

        // Two-flop synchroniser, sampler and edge pulse for one pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                smp_q  <= 1'b0;
                fall_q <= 1'b0;
            end else begin
                s1_q <= pin[g];
                s2_q <= s1_q;
                if (phase_q) begin
                    smp_q  <= s2_q;
                    fall_q <= smp_q & ~s2_q;
                end else begin
                    fall_q <= 1'b0;
                end
            end
        end
        assign fall[g] = fall_q;
    end
endmodule

// File: rtl/tt_counter.sv
// One timer unit: low/high count bytes, reload pair and mode logic.
// Assumes the caller already combined run, gate and event source into
// en_main / en_split. A write to either count byte cancels the step.
module tt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic         en_main,
    input  logic         en_split,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic         wr_rlo,
    input  logic         wr_rhi,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi,
    output logic [W-1:0] rlo,
    output logic [W-1:0] rhi,
    output logic         ovf_main,
    output logic         ovf_split
);
    import tt_pkg::*;
    localparam logic [W-1:0]   ONE1 = W'(1);
    localparam logic [2*W-1:0] ONE2 = (2*W)'(1);

    logic [W-1:0]   lo_q, hi_q, rlo_q, rhi_q;
    logic [2*W-1:0] word;
    logic           cnt_wr, lo_full, hi_full;

    assign word    = {hi_q, lo_q};
    assign cnt_wr  = wr_lo | wr_hi;
    assign lo_full = &lo_q;
    assign hi_full = &hi_q;

    // Overflow detection for the selected mode, suppressed by a count write
    always_comb begin
        ovf_main  = 1'b0;
        ovf_split = 1'b0;
        if (!cnt_wr) begin
            case (tmode_e'(mode))
                MODE_RELOAD16, MODE_FREE16: ovf_main = en_main & lo_full & hi_full;
                MODE_RELOAD8:               ovf_main = en_main & lo_full;
                default: begin
                    ovf_main  = en_main & lo_full;
                    ovf_split = en_split & hi_full;
                end
            endcase
        end
    end

    // Register writes first, otherwise one count step per mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            rlo_q <= '0;
            rhi_q <= '0;
        end else begin
            if (wr_rlo) rlo_q <= wr_data;
            if (wr_rhi) rhi_q <= wr_data;
            if (cnt_wr) begin
                if (wr_lo) lo_q <= wr_data;
                if (wr_hi) hi_q <= wr_data;
            end else begin
                case (tmode_e'(mode))
                    MODE_RELOAD16: if (en_main) {hi_q, lo_q} <= ovf_main ? {rhi_q, rlo_q} : word + ONE2;
                    MODE_FREE16:   if (en_main) {hi_q, lo_q} <= word + ONE2;
                    MODE_RELOAD8:  if (en_main) lo_q <= ovf_main ? rlo_q : lo_q + ONE1;
                    default: begin
                        if (en_main)  lo_q <= lo_q + ONE1;
                        if (en_split) hi_q <= hi_q + ONE1;
                    end
                endcase
            end
        end
    end

    assign lo  = lo_q;
    assign hi  = hi_q;
    assign rlo = rlo_q;
    assign rhi = rhi_q;
endmodule

// File: rtl/twin_reload_timer.sv
// Two auto-reload timer/counters with a shared prescaler, edge-counting
// inputs, gate inputs, overflow flags and toggle outputs.
// Assumes one synchronous write per cycle and a combinational read port.
module twin_reload_timer
    import tt_pkg::*;
#(
    parameter int PS_SH_A = 2,
    parameter int PS_SH_B = 4,
    parameter int PS_SH_C = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [1:0]        count_pin,
    input  logic [1:0]        gate_pin,
    input  logic [1:0]        irq_ack,
    output logic [1:0]        irq,
    output logic [1:0]        tog_out
);
    localparam int FW = 4;   // control field width per unit

    logic [BYTE_W-1:0] ctl_q;
    logic [1:0]        run_q, flag_q, oe_q, sel_q, tog_q;
    logic              tick, wr_run;
    logic [1:0]        fall, ev, en_main, en_split, ovf_main, ovf_split, ch_ovf;
    logic [1:0]        mode [N_UNIT];
    logic [1:0]        ct, gate, cnt_wr;
    logic [BYTE_W-1:0] cnt_lo [N_UNIT];
    logic [BYTE_W-1:0] cnt_hi [N_UNIT];
    logic [BYTE_W-1:0] rel_lo [N_UNIT];
    logic [BYTE_W-1:0] rel_hi [N_UNIT];

    assign wr_run = wr_en && (wr_addr == A_RUN);

    tt_prescale #(.SH_A(PS_SH_A), .SH_B(PS_SH_B), .SH_C(PS_SH_C)) u_ps (
        .clk(clk), .rst_n(rst_n), .sel(sel_q), .tick(tick)
    );

    tt_fall_detect #(.N(N_UNIT)) u_fd (
        .clk(clk), .rst_n(rst_n), .pin(count_pin), .fall(fall)
    );

    // Control and run/status bytes, except the flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            run_q <= '0;
            oe_q  <= '0;
            sel_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTL) ctl_q <= wr_data;
            if (wr_addr == A_RUN) begin
                run_q <= wr_data[1:0];
                oe_q  <= wr_data[5:4];
                sel_q <= wr_data[7:6];
            end
        end
    end

    for (genvar g = 0; g < N_UNIT; g++) begin : g_unit
        assign mode[g] = ctl_q[FW*g +: 2];
        assign ct[g]   = ctl_q[FW*g + 2];
        assign gate[g] = ctl_q[FW*g + 3];
        assign ev[g]   = ct[g] ? fall[g] : tick;
        assign en_main[g] = run_q[g] & (~gate[g] | gate_pin[g]) & ev[g]
                          & ~((g == 1) && (mode[g] == MODE_SPLIT));
        assign en_split[g] = (g == 0) ? (run_q[1] & tick) : 1'b0;
        assign cnt_wr[g] = wr_en && ((wr_addr == unit_addr(g, 0)) || (wr_addr == unit_addr(g, 1)));

        tt_counter #(.W(BYTE_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .mode(mode[g]),
            .en_main(en_main[g]), .en_split(en_split[g]),
            .wr_lo (wr_en && (wr_addr == unit_addr(g, 0))),
            .wr_hi (wr_en && (wr_addr == unit_addr(g, 1))),
            .wr_rlo(wr_en && (wr_addr == unit_addr(g, 2))),
            .wr_rhi(wr_en && (wr_addr == unit_addr(g, 3))),
            .wr_data(wr_data),
            .lo(cnt_lo[g]), .hi(cnt_hi[g]), .rlo(rel_lo[g]), .rhi(rel_hi[g]),
            .ovf_main(ovf_main[g]), .ovf_split(ovf_split[g])
        );

        // Flag: software write, then hardware set, then acknowledge
        always_ff @(posedge clk) begin
            if (!rst_n)                     flag_q[g] <= 1'b0;
            else if (wr_run)                flag_q[g] <= wr_data[2 + g];
            else if (ch_ovf[g] && !oe_q[g]) flag_q[g] <= 1'b1;
            else if (irq_ack[g])            flag_q[g] <= 1'b0;
        end

        // Toggle output inverts on each overflow while enabled
        always_ff @(posedge clk) begin
            if (!rst_n)                    tog_q[g] <= 1'b0;
            else if (ch_ovf[g] && oe_q[g]) tog_q[g] <= ~tog_q[g];
        end
    end

    // Channel 1 is taken over by unit 0's upper half in split mode
    assign ch_ovf[0] = ovf_main[0];
    assign ch_ovf[1] = (mode[0] == MODE_SPLIT) ? ovf_split[0] : (ovf_main[1] | ovf_split[1]);

    // Combinational register read
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTL) rd_data = ctl_q;
        if (rd_addr == A_RUN) rd_data = {sel_q, oe_q, flag_q, run_q};
        for (int n = 0; n < N_UNIT; n++) begin
            if (rd_addr == unit_addr(n, 0)) rd_data = cnt_lo[n];
            if (rd_addr == unit_addr(n, 1)) rd_data = cnt_hi[n];
            if (rd_addr == unit_addr(n, 2)) rd_data = rel_lo[n];
            if (rd_addr == unit_addr(n, 3)) rd_data = rel_hi[n];
        end
    end

    assign irq     = flag_q;
    assign tog_out = tog_q;
endmodule

// File: rtl/tt_checker.sv
// Temporal checks for twin_reload_timer, attached by bind.
module tt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode0,
    input logic [1:0] mode1,
    input logic [1:0] oe,
    input logic [1:0] irq,
    input logic [1:0] irq_ack,
    input logic [1:0] tog_out,
    input logic [1:0] ch_ovf,
    input logic       wr_run,
    input logic       t0_cnt_wr,
    input logic       t1_cnt_wr,
    input logic [7:0] t0_lo,
    input logic [7:0] t0_hi,
    input logic [7:0] t0_rlo,
    input logic [7:0] t0_rhi,
    input logic [7:0] t1_lo,
    input logic [7:0] t1_hi
);
    AST_M0_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == 2'd0 && ch_ovf[0]) |=> ({t0_hi, t0_lo} == $past({t0_rhi, t0_rlo}))); // R3

    AST_M2_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == 2'd2 && !t0_cnt_wr) |=> $stable(t0_hi)); // R5

    AST_T1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 == 2'd3 && !t1_cnt_wr) |=> $stable({t1_hi, t1_lo})); // R6

    AST_TOG_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tog_out[0]) |-> ($past(oe[0]) && $past(ch_ovf[0]))); // R9

    AST_FLAG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[1]) |-> ($past(wr_run) || !$past(oe[1]))); // R9

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[0] && irq_ack[0] && !ch_ovf[0] && !wr_run) |=> !irq[0]); // R10

    AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ovf[1] && !oe[1] && !wr_run) |=> irq[1]); // R10
endmodule

bind twin_reload_timer tt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mode0(mode[0]), .mode1(mode[1]), .oe(oe_q),
    .irq(irq), .irq_ack(irq_ack), .tog_out(tog_out), .ch_ovf(ch_ovf),
    .wr_run(wr_run), .t0_cnt_wr(cnt_wr[0]), .t1_cnt_wr(cnt_wr[1]),
    .t0_lo(cnt_lo[0]), .t0_hi(cnt_hi[0]), .t0_rlo(rel_lo[0]), .t0_rhi(rel_hi[0]),
    .t1_lo(cnt_lo[1]), .t1_hi(cnt_hi[1])
);

// File: tb/sim_twin_reload_timer.sv
module sim_twin_reload_timer;
    localparam int CLK_P = 10;
    localparam int WD_LIMIT = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] count_pin = '0;
    logic [1:0] gate_pin = '0;
    logic [1:0] irq_ack = '0;
    logic [1:0] irq;
    logic [1:0] tog_out;

    int    n_chk = 0;
    int    n_bad = 0;
    int    wd = 0;
    bit    live = 1'b0;
    string cur_req = "R1";

    always #(CLK_P/2) clk = ~clk;

    twin_reload_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .count_pin(count_pin), .gate_pin(gate_pin),
        .irq_ack(irq_ack), .irq(irq), .tog_out(tog_out)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_ctl;
    logic [1:0] m_run, m_flag, m_oe, m_sel, m_tog;
    logic [7:0] m_lo [2];
    logic [7:0] m_hi [2];
    logic [7:0] m_rlo [2];
    logic [7:0] m_rhi [2];
    logic [1:0] m_s1, m_s2, m_smp, m_fall;
    logic       m_ph;
    logic [5:0] m_pc;

    logic       t_tick, t_osp, t_wrc;
    logic [1:0] t_en, t_om, t_ch, t_mode, t_fall;
    logic [15:0] t_w;
    logic [7:0] t_lo [2];
    logic [7:0] t_hi [2];

    function automatic logic ref_tick(input logic [1:0] s, input logic [5:0] pc);
        case (s)
            2'd0:    return pc[1:0] == 2'b11;
            2'd1:    return pc[3:0] == 4'hF;
            2'd2:    return pc == 6'h3F;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] ref_read(input logic [3:0] a);
        case (a)
            4'd0: return m_ctl;
            4'd1: return {m_sel, m_oe, m_flag, m_run};
            4'd2: return m_lo[0];  4'd3: return m_hi[0];
            4'd4: return m_rlo[0]; 4'd5: return m_rhi[0];
            4'd6: return m_lo[1];  4'd7: return m_hi[1];
            4'd8: return m_rlo[1]; 4'd9: return m_rhi[1];
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = '0; m_run = '0; m_flag = '0; m_oe = '0; m_sel = '0; m_tog = '0;
            for (int n = 0; n < 2; n++) begin
                m_lo[n] = '0; m_hi[n] = '0; m_rlo[n] = '0; m_rhi[n] = '0;
            end
            m_s1 = '0; m_s2 = '0; m_smp = '0; m_fall = '0; m_ph = 1'b0; m_pc = '0;
        end else begin
            t_tick = ref_tick(m_sel, m_pc);
            t_om = '0; t_osp = 1'b0;
            for (int n = 0; n < 2; n++) begin
                t_mode = m_ctl[4*n +: 2];
                t_en[n] = m_run[n] && (!m_ctl[4*n+3] || gate_pin[n])
                          && (m_ctl[4*n+2] ? m_fall[n] : t_tick);
                t_lo[n] = m_lo[n]; t_hi[n] = m_hi[n];
                t_w = {m_hi[n], m_lo[n]};
                t_wrc = wr_en && (wr_addr == 4'(2+4*n) || wr_addr == 4'(3+4*n));
                if (!t_wrc) begin
                    case (t_mode)
                        2'd0: if (t_en[n]) begin
                            if (t_w == 16'hFFFF) begin
                                t_lo[n] = m_rlo[n]; t_hi[n] = m_rhi[n]; t_om[n] = 1'b1;
                            end else {t_hi[n], t_lo[n]} = t_w + 16'd1;
                        end
                        2'd1: if (t_en[n]) begin
                            t_om[n] = (t_w == 16'hFFFF);
                            {t_hi[n], t_lo[n]} = t_w + 16'd1;
                        end
                        2'd2: if (t_en[n]) begin
                            if (m_lo[n] == 8'hFF) begin t_lo[n] = m_rlo[n]; t_om[n] = 1'b1; end
                            else t_lo[n] = m_lo[n] + 8'd1;
                        end
                        default: if (n == 0) begin
                            if (t_en[0]) begin t_om[0] = (m_lo[0] == 8'hFF); t_lo[0] = m_lo[0] + 8'd1; end
                            if (m_run[1] && t_tick) begin t_osp = (m_hi[0] == 8'hFF); t_hi[0] = m_hi[0] + 8'd1; end
                        end
                    endcase
                end
            end
            t_ch[0] = t_om[0];
            t_ch[1] = (m_ctl[1:0] == 2'd3) ? t_osp : t_om[1];
            for (int n = 0; n < 2; n++) begin
                if (t_ch[n] && m_oe[n]) m_tog[n] = ~m_tog[n];
                if (wr_en && wr_addr == 4'd1) m_flag[n] = wr_data[2+n];
                else if (t_ch[n] && !m_oe[n]) m_flag[n] = 1'b1;
                else if (irq_ack[n]) m_flag[n] = 1'b0;
            end
            for (int n = 0; n < 2; n++) begin
                m_lo[n] = t_lo[n]; m_hi[n] = t_hi[n];
                if (wr_en && wr_addr == 4'(2+4*n)) m_lo[n] = wr_data;
                if (wr_en && wr_addr == 4'(3+4*n)) m_hi[n] = wr_data;
                if (wr_en && wr_addr == 4'(4+4*n)) m_rlo[n] = wr_data;
                if (wr_en && wr_addr == 4'(5+4*n)) m_rhi[n] = wr_data;
            end
            if (wr_en && wr_addr == 4'd0) m_ctl = wr_data;
            if (wr_en && wr_addr == 4'd1) begin
                m_run = wr_data[1:0]; m_oe = wr_data[5:4]; m_sel = wr_data[7:6];
            end
            t_fall = m_ph ? (m_smp & ~m_s2) : 2'b00;
            if (m_ph) m_smp = m_s2;
            m_s2 = m_s1; m_s1 = count_pin; m_ph = ~m_ph; m_fall = t_fall;
            m_pc = m_pc + 6'd1;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    // Lockstep comparison, away from the active edge
    always @(negedge clk) begin
        if (live) chk(cur_req, {20'd0, tog_out, irq, rd_data},
                      {20'd0, m_tog, m_flag, ref_read(rd_addr)});
    end

    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT) begin
            n_chk++; n_bad++;
            $display("FAIL R1: watchdog actual %0d expected %0d cycles", wd, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input int a);
        @(negedge clk); #1;
        wr_en = 1'b0; irq_ack = 2'b00;
        rd_addr = (a < 0) ? 4'($urandom_range(0, 11)) : 4'(a);
    endtask
    task automatic wr(input int a, input logic [7:0] d);
        step(-1); wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(-1);
    endtask
    task automatic peek(input int a, output logic [7:0] v);
        step(a); #1; v = rd_data;
    endtask

    logic [7:0] v;

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        @(negedge clk); #1; rst_n = 1'b1; live = 1'b1;

        cur_req = "R1";
        for (int a = 0; a < 12; a++) begin peek(a, v); chk("R1", v, 8'h00); end
        chk("R9", tog_out, 2'b00);
        wr(9, 8'hA5); peek(9, v); chk("R1", v, 8'hA5);
        wr(12, 8'hFF); peek(12, v); chk("R1", v, 8'h00);

        cur_req = "R2";
        wr(2, 8'h00); wr(3, 8'h00); wr(0, 8'h01);
        wr(1, 8'hC1); idle(100); peek(2, v); chk("R2", v, 8'h00);
        wr(1, 8'h01); idle(200); wr(1, 8'h41); idle(300); wr(1, 8'h81); idle(400);

        cur_req = "R3";
        wr(1, 8'h00); wr(0, 8'h00); wr(4, 8'h34); wr(5, 8'h12);
        wr(2, 8'hF0); wr(3, 8'hFF); wr(1, 8'h01); idle(120);
        chk("R3", irq[0], 1'b1); peek(3, v); chk("R3", v, 8'h12);

        cur_req = "R4";
        wr(1, 8'h00); wr(0, 8'h01); wr(2, 8'hF8); wr(3, 8'hFF); wr(1, 8'h01); idle(100);
        chk("R4", irq[0], 1'b1); peek(3, v); chk("R4", v, 8'h00);

        cur_req = "R5";
        wr(1, 8'h00); wr(0, 8'h02); wr(3, 8'h5A); wr(2, 8'hF0); wr(4, 8'hE0);
        wr(1, 8'h01); idle(400); peek(3, v); chk("R5", v, 8'h5A);

        cur_req = "R6";
        wr(1, 8'h00); wr(0, 8'h33); wr(6, 8'h11); wr(7, 8'h22); wr(3, 8'hFC);
        wr(1, 8'h03); idle(400);
        peek(6, v); chk("R6", v, 8'h11); peek(7, v); chk("R6", v, 8'h22);
        chk("R6", irq[1], 1'b1);
        wr(1, 8'h00); wr(0, 8'h13); wr(6, 8'hF0); wr(7, 8'hFF); wr(1, 8'h02); idle(300);

        cur_req = "R7";
        wr(1, 8'h00); wr(0, 8'h09); wr(2, 8'h00); wr(3, 8'h00); gate_pin = 2'b00;
        wr(1, 8'h01); idle(60); peek(2, v); chk("R7", v, 8'h00);
        gate_pin = 2'b01; idle(60); gate_pin = 2'b00; idle(40);

        cur_req = "R8";
        wr(1, 8'h00); wr(0, 8'h05); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h01);
        for (int p = 0; p < 10; p++) begin
            count_pin[0] = 1'b1; idle(4); count_pin[0] = 1'b0; idle(4);
        end
        idle(6); peek(2, v); chk("R8", v, 8'h0A);

        cur_req = "R9";
        wr(1, 8'h00); wr(0, 8'h01); wr(2, 8'hF0); wr(3, 8'hFF); wr(1, 8'h31); idle(120);
        chk("R9", tog_out[0], 1'b1); chk("R9", irq[0], 1'b0);

        cur_req = "R10";
        wr(1, 8'h00); wr(0, 8'h01); wr(2, 8'hFC); wr(3, 8'hFF); wr(1, 8'h01); idle(40);
        chk("R10", irq[0], 1'b1);
        step(-1); irq_ack = 2'b01; step(-1); chk("R10", irq[0], 1'b0);
        wr(1, 8'h0C); step(-1); chk("R10", irq, 2'b11);

        cur_req = "R11";
        wr(1, 8'h01); wr(0, 8'h01);
        for (int i = 0; i < 8; i++) wr(2, 8'h77);
        peek(2, v); chk("R11", v, 8'h77);

        cur_req = "R11";
        for (int i = 0; i < 4000; i++) begin
            step(-1);
            count_pin = 2'($urandom_range(0, 3));
            gate_pin  = 2'($urandom_range(0, 3));
            irq_ack   = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            if ($urandom_range(0, 9) == 0) begin
                wr_en = 1'b1; wr_addr = 4'($urandom_range(0, 11)); wr_data = 8'($urandom);
                if (wr_addr == 4'd1 && wr_data[7:6] == 2'd2) wr_data[7:6] = 2'd0;
            end
        end
        idle(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule